// File: doc/BRIEF.md
# Delayed-Branch Next-Fetch-Address Resolver

This block resolves the two upcoming fetch addresses of a processor that has one branch delay slot. Each cycle in which a decoded branch is presented, it takes the address of the branch (`pc`), the address of the delay slot (`npc`), and the address that follows the slot (`nnpc`). From these, the branch descriptor and the floating-point status word, it works out where fetch continues. One cycle later it returns the replacement `npc`/`nnpc` pair. It also returns a squash flag that stops the delay-slot instruction at the old `npc` from committing.

The 4-bit condition code picks the branch kind. Code 0x8 is branch-always, code 0x0 is branch-never, and every other code is a conditional branch. The annul bit acts differently in each kind. For integer branches, the truth of the condition is evaluated outside the block and arrives on `int_cond_ok`. For floating-point branches, the block selects one of four 2-bit comparison fields from the status word and evaluates the condition code against that field.

The block is built around a registered outcome state. On each clock edge, the state takes one of five values. `OC_IDLE` means no request was presented. `OC_SEQ` means sequential flow is unchanged. `OC_JUMP` means the delay slot runs and the target follows it. `OC_JUMP_SKIP` means the slot is squashed and fetch resumes at the target. `OC_STEP_SKIP` means the slot is squashed and fetch steps past it. Every transition goes from any state to the value classified from the present request, or to `OC_IDLE` when `br_valid` is low.

Top module: `nbr_nextpc`

## Requirements
- R1: After reset, and in every cycle that follows a cycle with `br_valid` low, `out_valid`, `squash`, `new_npc` and `new_nnpc` are all zero. A request sampled at one rising edge produces `out_valid`=1 after that edge.
- R2: Branch-always (cond 0x8) with annul clear gives new_npc = npc and new_nnpc = target. Squash stays 0.
- R3: Branch-always with annul set gives new_npc = target and new_nnpc = target+4. Squash is 1.
- R4: Branch-never (cond 0x0) with annul clear gives new_npc = npc and new_nnpc = nnpc. Squash stays 0.
- R5: Branch-never with annul set gives new_npc = npc+4 and new_nnpc = npc+8. Squash is 1.
- R6: A conditional branch (cond not 0x0 or 0x8) that is taken gives new_npc = npc and new_nnpc = target, with squash 0, whatever the annul bit.
- R7: A conditional branch that is not taken behaves like R4 when annul is clear and like R5 when annul is set.
- R8: target = pc + (sign-extended 22-bit `br_disp` × 4), computed modulo 2^64.
- R9: For a floating-point branch with `br_sel_en`=1, `br_fcc_sel` 0/1/2/3 reads status bits 11:10 / 33:32 / 35:34 / 37:36. With `br_sel_en`=0, bits 11:10 are read whatever `br_fcc_sel` holds.
- R10: A field value of 0 means equal, 1 less, 2 greater and 3 unordered. A floating-point condition is true for these sets: 0x8 all; 0x9 {E}; 0xA {U,E}; 0xB {G,E}; 0xC {U,G,E}; 0xD {L,E}; 0xE {U,L,E}; 0xF {E,L,G}. Each code c from 0x0 to 0x7 is true for exactly the complement of the set of c+8.
- R11: `int_cond_ok` has no effect on a floating-point branch, and `fsr` has no effect on an integer branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| br_valid | input | 1 | A branch request is presented this cycle |
| br_is_fp | input | 1 | 1 = floating-point branch, 0 = integer branch |
| br_sel_en | input | 1 | Floating-point form carries a field selector |
| br_fcc_sel | input | 2 | Which floating-point comparison field to read |
| br_cond | input | 4 | Condition code (0x8 always, 0x0 never) |
| br_annul | input | 1 | Annul bit |
| br_disp | input | 22 | Word displacement, signed |
| int_cond_ok | input | 1 | Externally evaluated integer condition |
| pc | input | 64 | Address of the branch |
| npc | input | 64 | Address of the delay slot |
| nnpc | input | 64 | Address after the delay slot |
| fsr | input | 64 | Floating-point status word |
| out_valid | output | 1 | Result of last cycle's request is present |
| new_npc | output | 64 | Next delay-slot-position address |
| new_nnpc | output | 64 | Address following it |
| squash | output | 1 | Instruction at the old npc must not commit |

## Verification
A wrong outcome state shows up on the ports in the very cycle after the request. A skipping state that should not be there raises `squash` and moves `new_npc` off the old `npc`. A jumping state that should be a sequential one puts the target on `new_nnpc`. A state that sticks instead of returning to `OC_IDLE` leaves `out_valid` high with no request. Because every request is compared one cycle after it is sampled, a misclassification is caught at once. The comparison covers every condition code against every field value, each field position, and negative displacements.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
    typedef enum logic [2:0] {
        OC_IDLE,
        OC_SEQ,
        OC_JUMP,
        OC_JUMP_SKIP,
        OC_STEP_SKIP
    } outcome_e;

    localparam logic [3:0] COND_NEVER  = 4'h0;
    localparam logic [3:0] COND_ALWAYS = 4'h8;

    // comparison field values
    localparam int FCC_EQ = 0;
    localparam int FCC_LT = 1;
    localparam int FCC_GT = 2;
    localparam int FCC_UN = 3;
endpackage

// File: rtl/nbr_fcc_pick.sv
module nbr_fcc_pick #(
    parameter int FSR_W = 64
) (
    input  logic [FSR_W-1:0] fsr,
    input  logic             sel_en,
    input  logic [1:0]       sel,
    output logic [1:0]       fcc
);
    localparam int NFIELD = 4;
    // low bit of each field; positions are fixed by the status word layout
    localparam int FIELD_LO [NFIELD] = '{10, 32, 34, 36};

    logic [1:0] fields [NFIELD];

    for (genvar g = 0; g < NFIELD; g++) begin : g_field
        assign fields[g] = fsr[FIELD_LO[g] +: 2];
    end

    logic [1:0] idx;
    assign idx = sel_en ? sel : 2'd0;
    assign fcc = fields[idx];
endmodule

// File: rtl/nbr_fcc_eval.sv
module nbr_fcc_eval (
    input  logic [3:0] cond,
    input  logic [1:0] fcc,
    output logic       ok
);
    // mask bit n set => taken when field value is n (E=0, L=1, G=2, U=3)
    logic [3:0] mask;

    always_comb begin
        unique case (cond)
            4'h0: mask = 4'b0000;
            4'h1: mask = 4'b1110;
            4'h2: mask = 4'b0110;
            4'h3: mask = 4'b1010;
            4'h4: mask = 4'b0010;
            4'h5: mask = 4'b1100;
            4'h6: mask = 4'b0100;
            4'h7: mask = 4'b1000;
            4'h8: mask = 4'b1111;
            4'h9: mask = 4'b0001;
            4'hA: mask = 4'b1001;
            4'hB: mask = 4'b0101;
            4'hC: mask = 4'b1101;
            4'hD: mask = 4'b0011;
            4'hE: mask = 4'b1011;
            4'hF: mask = 4'b0111;
            default: mask = 4'b0000;
        endcase
    end

    assign ok = mask[fcc];
endmodule

// File: rtl/nbr_target.sv
module nbr_target #(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 22
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] target
);
    localparam int EXT_W = ADDR_W - DISP_W - 2;

    logic [ADDR_W-1:0] offset;
    assign offset = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
    assign target = base + offset;
endmodule

// File: rtl/nbr_nextpc.sv
module nbr_nextpc
    import nbr_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 22,
    parameter int FSR_W  = 64,
    parameter int INSN_B = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic              br_is_fp,
    input  logic              br_sel_en,
    input  logic [1:0]        br_fcc_sel,
    input  logic [3:0]        br_cond,
    input  logic              br_annul,
    input  logic [DISP_W-1:0] br_disp,
    input  logic              int_cond_ok,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] npc,
    input  logic [ADDR_W-1:0] nnpc,
    input  logic [FSR_W-1:0]  fsr,
    output logic              out_valid,
    output logic [ADDR_W-1:0] new_npc,
    output logic [ADDR_W-1:0] new_nnpc,
    output logic              squash
);
    localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(INSN_B);
    localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 * INSN_B);

    logic [1:0]        fcc;
    logic              fp_ok;
    logic [ADDR_W-1:0] target;

    nbr_fcc_pick #(.FSR_W(FSR_W)) u_pick (
        .fsr    (fsr),
        .sel_en (br_sel_en),
        .sel    (br_fcc_sel),
        .fcc    (fcc)
    );

    nbr_fcc_eval u_eval (
        .cond (br_cond),
        .fcc  (fcc),
        .ok   (fp_ok)
    );

    nbr_target #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
        .base   (pc),
        .disp   (br_disp),
        .target (target)
    );

    // classification of the presented request
    outcome_e st, st_nxt;
    logic     cond_ok;

    assign cond_ok = br_is_fp ? fp_ok : int_cond_ok;

    always_comb begin
        if (!br_valid)
            st_nxt = OC_IDLE;
        else if (br_cond == COND_ALWAYS)
            st_nxt = br_annul ? OC_JUMP_SKIP : OC_JUMP;
        else if (br_cond == COND_NEVER)
            st_nxt = br_annul ? OC_STEP_SKIP : OC_SEQ;
        else if (cond_ok)
            st_nxt = OC_JUMP;
        else
            st_nxt = br_annul ? OC_STEP_SKIP : OC_SEQ;
    end

    // state register and captured addresses
    logic [ADDR_W-1:0] r_npc, r_nnpc, r_tgt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= OC_IDLE;
            r_npc  <= '0;
            r_nnpc <= '0;
            r_tgt  <= '0;
        end else begin
            st     <= st_nxt;
            r_npc  <= npc;
            r_nnpc <= nnpc;
            r_tgt  <= target;
        end
    end

    // outputs from state
    always_comb begin
        out_valid = 1'b1;
        squash    = 1'b0;
        new_npc   = '0;
        new_nnpc  = '0;
        unique case (st)
            OC_IDLE: begin
                out_valid = 1'b0;
            end
            OC_SEQ: begin
                new_npc  = r_npc;
                new_nnpc = r_nnpc;
            end
            OC_JUMP: begin
                new_npc  = r_npc;
                new_nnpc = r_tgt;
            end
            OC_JUMP_SKIP: begin
                new_npc  = r_tgt;
                new_nnpc = r_tgt + STEP1;
                squash   = 1'b1;
            end
            OC_STEP_SKIP: begin
                new_npc  = r_npc + STEP1;
                new_nnpc = r_npc + STEP2;
                squash   = 1'b1;
            end
            default: begin
                out_valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/nbr_nextpc_chk.sv
module nbr_nextpc_chk #(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 22,
    parameter int INSN_B = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              br_valid,
    input logic              br_is_fp,
    input logic [3:0]        br_cond,
    input logic              br_annul,
    input logic              int_cond_ok,
    input logic [ADDR_W-1:0] npc,
    input logic [ADDR_W-1:0] nnpc,
    input logic              out_valid,
    input logic [ADDR_W-1:0] new_npc,
    input logic [ADDR_W-1:0] new_nnpc,
    input logic              squash
);
    logic seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!squash && new_npc == '0 && new_nnpc == '0));

    a_r1_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (out_valid == $past(br_valid)));

    // R3, R5, R7: a squashed slot always resumes at two consecutive words
    a_r5_skip_pair: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> (new_nnpc == new_npc + ADDR_W'(INSN_B)));

    a_r4_never_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(br_valid && br_cond == 4'h0 && !br_annul))
        |-> (new_npc == $past(npc) && new_nnpc == $past(nnpc) && !squash));

    a_r6_taken_keeps_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(br_valid && !br_is_fp && int_cond_ok &&
                       br_cond != 4'h0 && br_cond != 4'h8))
        |-> (!squash && new_npc == $past(npc)));
endmodule

bind nbr_nextpc nbr_nextpc_chk #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .INSN_B(INSN_B)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .br_valid    (br_valid),
    .br_is_fp    (br_is_fp),
    .br_cond     (br_cond),
    .br_annul    (br_annul),
    .int_cond_ok (int_cond_ok),
    .npc         (npc),
    .nnpc        (nnpc),
    .out_valid   (out_valid),
    .new_npc     (new_npc),
    .new_nnpc    (new_nnpc),
    .squash      (squash)
);

// File: tb/nbr_nextpc_test.sv
module nbr_nextpc_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0, br_is_fp = 1'b0, br_sel_en = 1'b0;
    logic [1:0]  br_fcc_sel = '0;
    logic [3:0]  br_cond = '0;
    logic        br_annul = 1'b0;
    logic [21:0] br_disp = '0;
    logic        int_cond_ok = 1'b0;
    logic [63:0] pc = '0, npc = '0, nnpc = '0, fsr = '0;
    logic        out_valid, squash;
    logic [63:0] new_npc, new_nnpc;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nbr_nextpc uut (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_is_fp(br_is_fp),
        .br_sel_en(br_sel_en), .br_fcc_sel(br_fcc_sel), .br_cond(br_cond),
        .br_annul(br_annul), .br_disp(br_disp), .int_cond_ok(int_cond_ok),
        .pc(pc), .npc(npc), .nnpc(nnpc), .fsr(fsr),
        .out_valid(out_valid), .new_npc(new_npc), .new_nnpc(new_nnpc), .squash(squash)
    );

    // expected results of the last driven request
    logic        e_valid, e_squash;
    logic [63:0] e_npc, e_nnpc;
    string       e_tag;

    function automatic bit fp_true(input logic [3:0] c, input int v);
        logic [3:0] m;
        case (c | 4'h8)
            4'h8: m = 4'b1111;
            4'h9: m = 4'b0001;
            4'hA: m = 4'b1001;
            4'hB: m = 4'b0101;
            4'hC: m = 4'b1101;
            4'hD: m = 4'b0011;
            4'hE: m = 4'b1011;
            default: m = 4'b0111;
        endcase
        if (!c[3]) m = ~m;
        return m[v];
    endfunction

    task automatic model(input string tag);
        longint sd;
        logic [63:0] tgt;
        int fv;
        bit ok;
        sd = longint'($signed(br_disp));
        tgt = pc + 64'(sd * 4);
        if (!br_sel_en) fv = int'(fsr[11:10]);
        else case (br_fcc_sel)
            2'd0: fv = int'(fsr[11:10]);
            2'd1: fv = int'(fsr[33:32]);
            2'd2: fv = int'(fsr[35:34]);
            default: fv = int'(fsr[37:36]);
        endcase
        ok = br_is_fp ? fp_true(br_cond, fv) : bit'(int_cond_ok);
        if (br_cond == 4'h8) ok = 1;
        if (br_cond == 4'h0) ok = 0;
        e_tag = tag;
        e_valid = br_valid;
        e_squash = 0; e_npc = 0; e_nnpc = 0;
        if (!br_valid) return;
        if (br_cond == 4'h8 && br_annul) begin
            e_npc = tgt; e_nnpc = tgt + 4; e_squash = 1;
        end else if (ok) begin
            e_npc = npc; e_nnpc = tgt;
        end else if (br_annul) begin
            e_npc = npc + 4; e_nnpc = npc + 8; e_squash = 1;
        end else begin
            e_npc = npc; e_nnpc = nnpc;
        end
    endtask

    task automatic compare();
        checks++;
        if (out_valid !== e_valid || squash !== e_squash ||
            new_npc !== e_npc || new_nnpc !== e_nnpc) begin
            errors++;
            $display("FAIL %s: got v=%0b sq=%0b npc=%h nnpc=%h, expected v=%0b sq=%0b npc=%h nnpc=%h",
                     e_tag, out_valid, squash, new_npc, new_nnpc,
                     e_valid, e_squash, e_npc, e_nnpc);
        end
    endtask

    // drive one request, then compare one edge later
    task automatic req(input bit v, input bit fp, input bit se, input logic [1:0] sel,
                       input logic [3:0] c, input bit a, input logic [21:0] d,
                       input bit iok, input logic [63:0] p, input logic [63:0] f,
                       input string tag);
        br_valid = v; br_is_fp = fp; br_sel_en = se; br_fcc_sel = sel;
        br_cond = c; br_annul = a; br_disp = d; int_cond_ok = iok;
        pc = p; npc = p + 4; nnpc = p + 8; fsr = f;
        model(tag);
        @(posedge clk);
        #(CLK_PERIOD/4);
        compare();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got running, expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        e_valid = 0; e_squash = 0; e_npc = 0; e_nnpc = 0; e_tag = "R1 reset";
        compare();
        rst_n = 1'b1;
        req(0, 0, 0, 0, 4'h8, 0, 22'h10, 0, 64'h1000, 0, "R1 idle");

        req(1, 0, 0, 0, 4'h8, 0, 22'h10, 0, 64'h1000, 0, "R2 always");
        req(1, 1, 1, 2, 4'h8, 0, 22'h20, 0, 64'h2000, 0, "R2 always fp");
        req(1, 0, 0, 0, 4'h8, 1, 22'h10, 0, 64'h1000, 0, "R3 always annul");
        req(1, 0, 0, 0, 4'h0, 0, 22'h10, 1, 64'h3000, 0, "R4 never");
        req(1, 1, 0, 0, 4'h0, 1, 22'h10, 1, 64'h3000, 0, "R5 never annul");
        req(0, 0, 0, 0, 4'h0, 0, 0, 0, 0, 0, "R1 back to idle");
        req(1, 0, 0, 0, 4'h3, 1, 22'h40, 1, 64'h4000, 0, "R6 taken annul");
        req(1, 0, 0, 0, 4'h3, 0, 22'h40, 1, 64'h4000, 0, "R6 taken");
        req(1, 0, 0, 0, 4'h3, 0, 22'h40, 0, 64'h4000, 0, "R7 not taken");
        req(1, 0, 0, 0, 4'h3, 1, 22'h40, 0, 64'h4000, 0, "R7 not taken annul");
        req(1, 0, 0, 0, 4'h8, 0, 22'h3FFFFF, 0, 64'h5000, 0, "R8 disp -1");
        req(1, 0, 0, 0, 4'h8, 1, 22'h200000, 0, 64'h0, 0, "R8 wrap");
        req(1, 0, 0, 0, 4'h8, 0, 22'h1FFFFF, 0, 64'hFFFF_FFFF_FFFF_FFF0, 0, "R8 max");

        // R9: only one field holds "greater" (2); cond 0x6 true only for it
        for (int s = 0; s < 4; s++) begin
            logic [63:0] f;
            int lo;
            lo = (s == 0) ? 10 : 30 + 2 * s;
            f = 64'h0;
            f[lo +: 2] = 2'd2;
            for (int q = 0; q < 4; q++)
                req(1, 1, 1, 2'(q), 4'h6, 1, 22'h8, 0, 64'h6000, f, "R9 field select");
            req(1, 1, 0, 2'd3, 4'h6, 1, 22'h8, 0, 64'h6000, f, "R9 no selector");
        end

        // R10: every condition code against every field value
        for (int c = 0; c < 16; c++)
            for (int v = 0; v < 4; v++)
                req(1, 1, 1, 2'd1, 4'(c), 1, 22'h12, 0, 64'h7000,
                    64'(v) << 32, "R10 fp condition");

        // R11: int_cond_ok on an fp branch, fsr on an integer branch
        req(1, 1, 1, 0, 4'h9, 1, 22'h4, 1, 64'h8000, 64'h0000_0000_0000_0400, "R11 int ignored fp");
        req(1, 1, 1, 0, 4'h9, 1, 22'h4, 0, 64'h8000, 64'h0, "R11 int ignored fp 2");
        req(1, 0, 1, 0, 4'h9, 1, 22'h4, 0, 64'h8000, 64'h0, "R11 fsr ignored int");
        req(1, 0, 1, 0, 4'h9, 1, 22'h4, 0, 64'h8000, 64'hFFFF_FFFF_FFFF_FFFF, "R11 fsr ignored int 2");

        for (int i = 0; i < 400; i++) begin
            logic [63:0] rp, rf;
            rp = {$urandom, $urandom} & ~64'h3;
            rf = {$urandom, $urandom};
            req(($urandom % 5) != 0, 1'($urandom), 1'($urandom), 2'($urandom),
                4'($urandom), 1'($urandom), 22'($urandom), 1'($urandom),
                rp, rf, "R6 R7 R10 mixed");
        end
        req(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 final idle");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule